// File: doc/BRIEF.md
# Trigger Gate Window Generator

This block decides when the hits of a multi-channel time-to-digital converter are recorded. A 32-bit control word picks what opens the acquisition gate: it can be held open for free-running capture, or opened by the A-side trigger, the B-side trigger, or their coincidence. A triggered gate stays open for a programmed number of clock cycles. At a 125 MHz clock, one count equals 8 ns.

Each cycle, the block combines 32 detector hit lines and three auxiliary lines (A, B and T = A AND B) with their enables and with the gate state. It registers the result as a 35-bit gated hit vector. A per-channel mask enables the detector channels. Three control bits enable the auxiliary channels.

The hit lines are level signals that are sampled on every clock. There is no handshake at either edge of the block, so the block cannot exert or receive back-pressure: every cycle produces exactly one output word. A downstream consumer that cannot take a word every cycle must buffer the words itself.

Top module: `tgw_gate_top`

## Requirements
- R1: While rst_n is low, hits_out is all zero and the gate is closed. No trigger history is kept across reset.
- R2: With ctrl_word bit 0 set, the gate is open on every cycle, so every enabled hit is passed without any trigger.
- R3: The trigger condition is the OR of three terms: A when bit 1 is set, B when bit 2 is set, and A AND B when bit 3 or bit 4 is set. Only a rising edge of this combined condition starts a window. A trigger whose source bit is clear has no effect, and a condition held high starts only one window.
- R4: ctrl_word bits 15:8 hold a width N. After the clock edge that samples the trigger edge, the gate is open for exactly N cycles, and each of those cycles passes hits.
- R5: A new trigger edge while the gate is open reloads the count with N, which extends the window.
- R6: A width of zero opens no window unless bit 0 is set.
- R7: Detector output bit n (0 to 31) is hits[n] AND chan_mask[n] AND gate.
- R8: Output bits 32, 33 and 34 carry A, B and A AND B. They are enabled by ctrl_word bits 5, 6 and 7 respectively, and are also gated.
- R9: ctrl_word bits 31:16 have no effect on the output.
- R10: hits_out is registered once: the word seen after a clock edge is formed from the inputs sampled at that edge and the gate state held before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Gate source, aux enables and width |
| trig_a | input | 1 | A-side coincidence trigger |
| trig_b | input | 1 | B-side coincidence trigger |
| chan_mask | input | 32 | Per-channel detector enable |
| hits | input | 32 | Raw detector hit lines |
| hits_out | output | 35 | Gated, registered hits, with auxiliary channels in bits 34:32 |

## Verification
A trigger edge sampled at clock edge k loads the window counter at k. The first gated word therefore appears after edge k+1, and the last one appears after edge k+N. A hit or mask change shows up on hits_out after the very next edge. The bench drives the inputs 1 ns after a rising edge and compares hits_out with a behavioural model at that same point, once per clock. It also counts the words with any bit set over each trigger scenario and checks that count against the window length the requirements call for.

// File: rtl/tgw_pkg.sv
package tgw_pkg;
  localparam int DET_CH   = 32;
  localparam int AUX_CH   = 3;
  localparam int WIDTH_W  = 8;
  localparam int CTRL_W   = 32;
  // control word bit positions
  localparam int CB_FORCE = 0;
  localparam int CB_SRC_A = 1;
  localparam int CB_SRC_B = 2;
  localparam int CB_SRC_T0 = 3;
  localparam int CB_SRC_T1 = 4;
  localparam int CB_AUX_LO = 5;
  localparam int CB_WID_LO = 8;
  localparam int CB_USED   = CB_WID_LO + WIDTH_W;

  typedef struct packed {
    logic               force_open;
    logic               src_a;
    logic               src_b;
    logic               src_t;
    logic [AUX_CH-1:0]  aux_en;
    logic [WIDTH_W-1:0] width;
  } gate_cfg_t;
endpackage

// File: rtl/tgw_cfg_decode.sv
module tgw_cfg_decode
  import tgw_pkg::*;
(
  input  logic [CB_USED-1:0] ctrl_low,
  output gate_cfg_t          cfg
);
  always_comb begin
    cfg.force_open = ctrl_low[CB_FORCE];
    cfg.src_a      = ctrl_low[CB_SRC_A];
    cfg.src_b      = ctrl_low[CB_SRC_B];
    cfg.src_t      = ctrl_low[CB_SRC_T0] | ctrl_low[CB_SRC_T1];
    cfg.aux_en     = ctrl_low[CB_AUX_LO +: AUX_CH];
    cfg.width      = ctrl_low[CB_WID_LO +: WIDTH_W];
  end
endmodule

// File: rtl/tgw_window.sv
module tgw_window
  import tgw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  gate_cfg_t          cfg,
  input  logic               trig_a,
  input  logic               trig_b,
  output logic               gate_open,
  output logic               trig_edge,
  output logic [WIDTH_W-1:0] remaining
);
  logic cond, cond_q;

  always_comb begin
    cond = (cfg.src_a & trig_a) |
           (cfg.src_b & trig_b) |
           (cfg.src_t & trig_a & trig_b);
  end

  assign trig_edge = cond & ~cond_q;
  assign gate_open = cfg.force_open | (remaining != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q    <= 1'b0;
      remaining <= '0;
    end else begin
      cond_q <= cond;
      if (trig_edge)
        remaining <= cfg.width;
      else if (remaining != '0)
        remaining <= remaining - 1'b1;
    end
  end
endmodule

// File: rtl/tgw_hit_gate.sv
module tgw_hit_gate #(
  parameter int N = 35
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] en,
  input  logic         gate_open,
  output logic [N-1:0] gated
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gated[i] <= 1'b0;
      else        gated[i] <= raw[i] & en[i] & gate_open;
    end
  end
endmodule

// File: rtl/tgw_gate_top.sv
module tgw_gate_top
  import tgw_pkg::*;
#(
  parameter int NUM_DET = DET_CH,
  localparam int NUM_OUT = NUM_DET + AUX_CH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CTRL_W-1:0]   ctrl_word,
  input  logic                trig_a,
  input  logic                trig_b,
  input  logic [NUM_DET-1:0]  chan_mask,
  input  logic [NUM_DET-1:0]  hits,
  output logic [NUM_OUT-1:0]  hits_out
);
  gate_cfg_t          cfg;
  logic               gate_open;
  logic               trig_edge;
  logic [WIDTH_W-1:0] remaining;
  logic [NUM_OUT-1:0] lane_raw;
  logic [NUM_OUT-1:0] lane_en;
  logic               ctrl_unused_hi;

  // upper control bits carry no function
  assign ctrl_unused_hi = ^ctrl_word[CTRL_W-1:CB_USED];

  tgw_cfg_decode u_dec (
    .ctrl_low (ctrl_word[CB_USED-1:0]),
    .cfg      (cfg)
  );

  tgw_window u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .trig_a    (trig_a),
    .trig_b    (trig_b),
    .gate_open (gate_open),
    .trig_edge (trig_edge),
    .remaining (remaining)
  );

  assign lane_raw = {trig_a & trig_b, trig_b, trig_a, hits};
  assign lane_en  = {cfg.aux_en, chan_mask};

  tgw_hit_gate #(.N(NUM_OUT)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw       (lane_raw),
    .en        (lane_en),
    .gate_open (gate_open),
    .gated     (hits_out)
  );
endmodule

// File: rtl/tgw_checker.sv
module tgw_checker
  import tgw_pkg::*;
#(
  parameter int NUM_DET = DET_CH
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [CTRL_W-1:0]          ctrl_word,
  input logic                       trig_a,
  input logic [NUM_DET-1:0]         chan_mask,
  input logic [NUM_DET+AUX_CH-1:0]  hits_out,
  input logic                       gate_open,
  input logic                       trig_edge,
  input logic [WIDTH_W-1:0]         remaining
);
  // R2: forced-open bit keeps the gate open
  p_force_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[CB_FORCE] |-> gate_open);

  // R4: a closed gate yields an empty word on the next edge
  p_closed_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_open |=> (hits_out == '0));

  // R4: the window counts down one per cycle when not retriggered
  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (remaining != '0 && !trig_edge) |=> (remaining == $past(remaining) - 1'b1));

  // R5: an edge reloads the programmed width
  p_edge_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_edge |=> (remaining == $past(ctrl_word[CB_WID_LO +: WIDTH_W])));

  // R6: zero width never opens a window from idle
  p_zero_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (remaining == '0 && ctrl_word[CB_WID_LO +: WIDTH_W] == '0) |=> (remaining == '0));

  // R7: no detector bit without its mask bit
  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((hits_out[NUM_DET-1:0] & ~$past(chan_mask)) == '0));

  // R8: aux A bit needs its enable and the trigger
  p_aux_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hits_out[NUM_DET] |-> ($past(ctrl_word[CB_AUX_LO]) && $past(trig_a)));
endmodule

bind tgw_gate_top tgw_checker #(.NUM_DET(NUM_DET)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_word (ctrl_word),
  .trig_a    (trig_a),
  .chan_mask (chan_mask),
  .hits_out  (hits_out),
  .gate_open (gate_open),
  .trig_edge (trig_edge),
  .remaining (remaining)
);

// File: tb/tgw_gate_top_tb_top.sv
`timescale 1ns/1ps
module tgw_gate_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic        trig_a = 1'b0;
  logic        trig_b = 1'b0;
  logic [31:0] chan_mask = '0;
  logic [31:0] hits = '0;
  logic [34:0] hits_out;

  int checks = 0;
  int errors = 0;
  int opened = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  tgw_gate_top dut_i (
    .clk (clk), .rst_n (rst_n), .ctrl_word (ctrl_word),
    .trig_a (trig_a), .trig_b (trig_b), .chan_mask (chan_mask),
    .hits (hits), .hits_out (hits_out)
  );

  // behavioural reference model
  logic [34:0] m_exp = '0;
  int          m_rem = 0;
  bit          m_prev = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_exp = '0; m_rem = 0; m_prev = 0;
    end else begin
      bit cnd, g;
      cnd = (ctrl_word[1] && trig_a) || (ctrl_word[2] && trig_b) ||
            ((ctrl_word[3] || ctrl_word[4]) && trig_a && trig_b);
      g = ctrl_word[0] || (m_rem > 0);
      for (int i = 0; i < 32; i++) m_exp[i] = hits[i] & chan_mask[i] & g;
      m_exp[32] = trig_a & ctrl_word[5] & g;
      m_exp[33] = trig_b & ctrl_word[6] & g;
      m_exp[34] = trig_a & trig_b & ctrl_word[7] & g;
      if (cnd && !m_prev) m_rem = int'(ctrl_word[15:8]);
      else if (m_rem > 0) m_rem = m_rem - 1;
      m_prev = cnd;
    end
  end

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    chk(cur_req, {29'd0, hits_out}, {29'd0, m_exp});
    if (|hits_out) opened++;
  endtask

  task automatic idle(int n);
    trig_a = 0; trig_b = 0;
    repeat (n) tick();
    opened = 0;
  endtask

  task automatic pulse(bit a, bit b);
    trig_a = a; trig_b = b; tick();
    trig_a = 0; trig_b = 0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    hits = '1; chan_mask = '1; ctrl_word = 32'h1;
    repeat (3) tick();
    chk("R1", {29'd0, hits_out}, 64'd0);
    rst_n = 1'b1;

    // R2 free running
    cur_req = "R2";
    ctrl_word = 32'h1; chan_mask = '1;
    hits = 32'h1234_5678; tick();
    chk("R2", {29'd0, hits_out}, 64'h1234_5678);
    repeat (20) begin hits = $urandom; tick(); end

    // R7 per-channel mask
    cur_req = "R7";
    hits = '1; chan_mask = 32'h0000_FFFF; tick();
    chk("R7", {29'd0, hits_out}, 64'h0000_FFFF);
    chan_mask = 32'h8000_0000; tick();
    chk("R7", {29'd0, hits_out}, 64'h8000_0000);
    repeat (20) begin hits = $urandom; chan_mask = $urandom; tick(); end

    // R4 window length
    cur_req = "R4";
    hits = '1; chan_mask = '1;
    ctrl_word = 32'h0000_0502; idle(10);
    pulse(1, 0); repeat (10) tick();
    chk("R4", opened, 5);

    // R6 zero width
    cur_req = "R6";
    ctrl_word = 32'h0000_0002; idle(4);
    pulse(1, 0); repeat (6) tick();
    chk("R6", opened, 0);

    // R5 retrigger
    cur_req = "R5";
    ctrl_word = 32'h0000_0402; idle(6);
    pulse(1, 0); tick(); pulse(1, 0); repeat (10) tick();
    chk("R5", opened, 6);

    // R3 source selection
    cur_req = "R3";
    ctrl_word = 32'h0000_0304; idle(6);
    pulse(1, 0); repeat (6) tick();
    chk("R3 A ignored in B mode", opened, 0);
    pulse(0, 1); repeat (6) tick();
    chk("R3 B mode", opened, 3);
    ctrl_word = 32'h0000_0308; idle(6);
    pulse(1, 0); repeat (4) tick(); pulse(0, 1); repeat (4) tick();
    chk("R3 single side ignored in T mode", opened, 0);
    pulse(1, 1); repeat (6) tick();
    chk("R3 T via bit3", opened, 3);
    ctrl_word = 32'h0000_0310; idle(6);
    pulse(1, 1); repeat (6) tick();
    chk("R3 T via bit4", opened, 3);
    ctrl_word = 32'h0000_0306; idle(6);
    trig_a = 1; repeat (3) tick(); trig_b = 1; repeat (8) tick();
    chk("R3 held condition one window", opened, 3);

    // R8 auxiliary channels
    cur_req = "R8";
    ctrl_word = 32'h0000_00E1; chan_mask = '0; hits = '0; idle(2);
    trig_a = 1; trig_b = 0; tick();
    chk("R8", {61'd0, hits_out[34:32]}, 64'h1);
    trig_a = 1; trig_b = 1; tick();
    chk("R8", {61'd0, hits_out[34:32]}, 64'h7);
    ctrl_word = 32'h0000_0041; tick();
    chk("R8", {61'd0, hits_out[34:32]}, 64'h2);
    ctrl_word = 32'h0000_02E2; idle(6);
    trig_a = 1; trig_b = 1; tick();
    chk("R8 gated aux", {61'd0, hits_out[34:32]}, 64'h0);
    trig_a = 0; trig_b = 0; repeat (4) tick();

    // R9 upper control bits
    cur_req = "R9";
    hits = '1; chan_mask = '1;
    ctrl_word = 32'hA5A5_0502; idle(8);
    pulse(1, 0); repeat (8) tick();
    chk("R9", opened, 5);
    ctrl_word = 32'hFFFF_0000; idle(4);
    pulse(1, 1); repeat (4) tick();
    chk("R9 no open from upper bits", opened, 0);

    // R10 random traffic against the model
    cur_req = "R10";
    repeat (400) begin
      ctrl_word = {$urandom} & 32'hFFFF_00FE;
      ctrl_word[15:8] = 8'($urandom % 6);
      ctrl_word[0] = ($urandom % 8) == 0;
      trig_a = $urandom; trig_b = $urandom;
      hits = $urandom; chan_mask = $urandom;
      tick();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule